// File: doc/BRIEF.md
# Segment Register Load Checker

This block sits beside the execution pipeline and handles the segment half of a far-pointer load. It takes the raw pointer bytes from memory and splits them into an offset and a 16-bit selector according to the operand size. It then runs the protection rules for the target segment register and either commits the new selector, hidden state and offset or reports a fault kind with an error code. The rules depend on the processor mode, the current privilege level (CPL) and the target register.

When a rule needs the descriptor, the block fetches it over a request/acknowledge port. The requester holds the inputs steady, pulses `start`, and waits for the one-cycle `done` pulse. On that cycle the fault outputs and the architectural outputs are valid, and they hold until the next request completes. Paging, alignment, lock decoding and the memory access itself are handled elsewhere.

Top module: `seg_load_guard`

## Requirements
- R1: Pointer split. `opsz`=2 in 64-bit mode gives a 64-bit offset from bytes 7:0 and the selector from bits 79:64. `opsz`=0 gives a 16-bit offset from bits 15:0 and the selector from bits 31:16. Any other case gives a 32-bit offset from bits 31:0 and the selector from bits 47:32. A committed offset is zero-extended onto `dest_off`.
- R2: In real mode (`mode`=0) or virtual-8086 mode (`mode`=1), the selector and the offset are written with no fault and no descriptor fetch. `seg_valid` and `seg_attr` of the target are left as they were.
- R3: A selector whose bits 15:2 are all zero is NULL. A NULL selector loaded into DS (`tgt`=1), ES (2), FS (3) or GS (4) in a checked mode never faults and never fetches. It writes the selector and the offset and clears the target's valid bit.
- R4: A NULL selector for SS (`tgt`=0) raises GP (`fault_kind`=1) with code 0 in protected (`mode`=2) or compatibility (`mode`=3) mode. In 64-bit mode (`mode`=4) it raises GP(0) only when RPL (bits 1:0) is 3 or differs from CPL. Otherwise it is accepted and the valid bit is cleared.
- R5: A non-NULL SS load raises GP with the selector as code when any of these hold: RPL ≠ CPL, DPL ≠ CPL, or the segment is not a writable data segment. Writable data means S=1, type bit 3 = 0 and type bit 1 = 1. If none of these hold and the present bit is 0, it raises SS (`fault_kind`=2) with the selector. A selector error code is always the selector with bits 1:0 cleared.
- R6: A non-NULL load of DS/ES/FS/GS raises GP(selector) in either of two cases. The first is when the segment is a system segment (S=0) or a code segment (type bit 3 = 1) that is not readable (type bit 1 = 0). The second is when it is a data segment or a nonconforming code segment (type bit 2 = 0) and RPL > DPL or CPL > DPL. If it passes these checks but is not present, it raises NP (`fault_kind`=3) with the selector.
- R7: In 64-bit mode, DS or ES as target raises UD (`fault_kind`=4) with code 0 and no fetch. In every checked mode, a selector index (bits 15:3) above `tbl_limit` raises GP(selector) without a fetch. In 64-bit mode, `desc_canon`=0 raises GP(selector) without a fetch. These checks take priority over the descriptor checks.
- R8: A successful non-NULL load in a checked mode writes the selector and the offset, sets the valid bit, and caches the attribute byte {P, DPL[1:0], S, type[3:0]} (bit 7 down to bit 0).
- R9: A fault leaves `seg_sel`, `seg_valid`, `seg_attr` and `dest_off` unchanged.
- R10: `done` is high for exactly one cycle per request. `desc_req` stays high until `desc_ack` is seen and is low while `done` is high. The fault outputs hold their value until the next request completes.
- R11: After reset, all selectors, valid bits, attributes, the offset, the fault kind and the fault code are zero, and `done` and `desc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; inputs are captured on this cycle |
| mode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| cpl | input | 2 | Current privilege level |
| tgt | input | 3 | Target register: 0 SS, 1 DS, 2 ES, 3 FS, 4 GS |
| opsz | input | 2 | 0 16-bit, 1 32-bit, 2 wide (64-bit mode only) |
| ptr | input | OFF_W+SEL_W | Raw pointer bytes from memory |
| tbl_limit | input | SEL_W-3 | Highest valid descriptor index |
| desc_canon | input | 1 | Descriptor address is canonical |
| desc_req | output | 1 | Descriptor fetch request |
| desc_idx | output | SEL_W-3 | Index of the descriptor wanted |
| desc_ack | input | 1 | Descriptor fields valid |
| desc_type | input | 4 | Descriptor type field |
| desc_s | input | 1 | Code/data (1) or system (0) |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Present bit |
| done | output | 1 | One-cycle completion pulse |
| fault_kind | output | 3 | 0 none, 1 GP, 2 SS, 3 NP, 4 UD |
| fault_code | output | 16 | Error code |
| dest_off | output | OFF_W | Destination offset |
| seg_sel | output | 5*SEL_W | Selectors, slot n at bits n*SEL_W |
| seg_valid | output | 5 | Hidden descriptor-valid bits |
| seg_attr | output | 40 | Cached attribute bytes, slot n at bits n*8 |

## Verification
The bench builds the block with its default widths: a 64-bit offset and a 16-bit selector. That makes the wide-pointer split of 64-bit mode reachable, and lets the junk placed above the narrow pointers show whether the split masks it. The table limit is an input set to 100, so selectors at index 100 and index 101 probe both sides of the limit comparison. A slow descriptor responder stretches the fetch to show that the request is held.

// File: rtl/segld_pkg.sv
`timescale 1ns/1ps
package segld_pkg;
  localparam int NUM_SEG = 5;
  localparam int ATTR_W  = 8;

  typedef enum logic [2:0] {MD_REAL = 3'd0, MD_V86 = 3'd1, MD_PROT = 3'd2,
                            MD_COMPAT = 3'd3, MD_LONG = 3'd4} cpu_mode_e;
  typedef enum logic [2:0] {SR_SS = 3'd0, SR_DS = 3'd1, SR_ES = 3'd2,
                            SR_FS = 3'd3, SR_GS = 3'd4} seg_id_e;
  typedef enum logic [2:0] {FK_NONE = 3'd0, FK_GP = 3'd1, FK_SS = 3'd2,
                            FK_NP = 3'd3, FK_UD = 3'd4} fault_e;
  typedef enum logic [1:0] {OS_16 = 2'd0, OS_32 = 2'd1, OS_64 = 2'd2} opsz_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_DONE} ld_state_e;

  typedef struct packed {
    logic       p;
    logic [1:0] dpl;
    logic       s;
    logic [3:0] typ;
  } desc_attr_t;
endpackage

// File: rtl/segld_ptr_split.sv
`timescale 1ns/1ps
module segld_ptr_split import segld_pkg::*; #(
  parameter int OFF_W = 64,
  parameter int SEL_W = 16
) (
  input  logic [OFF_W+SEL_W-1:0] ptr,
  input  logic [2:0]             mode,
  input  logic [1:0]             opsz,
  output logic [SEL_W-1:0]       sel,
  output logic [OFF_W-1:0]       off
);
  localparam int NARROW = 16;
  localparam int MID    = 32;

  always_comb begin
    off = '0;
    if (mode == MD_LONG && opsz == OS_64) begin
      off = ptr[OFF_W-1:0];
      sel = ptr[OFF_W +: SEL_W];
    end else if (opsz == OS_16) begin
      off[NARROW-1:0] = ptr[NARROW-1:0];
      sel = ptr[NARROW +: SEL_W];
    end else begin
      off[MID-1:0] = ptr[MID-1:0];
      sel = ptr[MID +: SEL_W];
    end
  end
endmodule

// File: rtl/segld_rules.sv
`timescale 1ns/1ps
module segld_rules import segld_pkg::*; #(
  parameter int SEL_W = 16,
  localparam int IDX_W = SEL_W - 3
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       cpl,
  input  logic [2:0]       tgt,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] limit,
  input  logic             canon,
  input  desc_attr_t       dsc,
  output logic             need_desc,
  output logic [2:0]       kind,
  output logic [15:0]      code,
  output logic             wr_sel,
  output logic             wr_valid,
  output logic             valid_val,
  output logic             wr_attr
);
  logic checked, wide, is_null, ud, lim_bad, canon_bad;
  logic is_code, conf, rw, ss_bad, dx_type_bad, dx_priv_bad;
  logic [1:0] rpl;
  logic [15:0] sel_code;

  assign checked   = (mode == MD_PROT) || (mode == MD_COMPAT) || (mode == MD_LONG);
  assign wide      = (mode == MD_LONG);
  assign rpl       = sel[1:0];
  assign is_null   = (sel[SEL_W-1:2] == '0);
  assign sel_code  = 16'({sel[SEL_W-1:2], 2'b00});
  assign ud        = wide && (tgt == SR_DS || tgt == SR_ES);
  assign lim_bad   = sel[SEL_W-1:3] > limit;
  assign canon_bad = wide && !canon;
  assign need_desc = checked && !ud && !is_null && !lim_bad && !canon_bad;

  assign is_code     = dsc.typ[3];
  assign conf        = dsc.typ[2];
  assign rw          = dsc.typ[1];
  assign ss_bad      = (rpl != cpl) || (dsc.dpl != cpl) || !dsc.s || is_code || !rw;
  assign dx_type_bad = !dsc.s || (is_code && !rw);
  assign dx_priv_bad = (!is_code || !conf) && ((rpl > dsc.dpl) || (cpl > dsc.dpl));

  always_comb begin
    kind = FK_NONE; code = '0;
    wr_sel = 1'b0; wr_valid = 1'b0; valid_val = 1'b0; wr_attr = 1'b0;
    if (!checked) begin
      wr_sel = 1'b1;
    end else if (ud) begin
      kind = FK_UD;
    end else if (is_null) begin
      if (tgt == SR_SS && (!wide || rpl == 2'd3 || rpl != cpl)) begin
        kind = FK_GP;
      end else begin
        wr_sel = 1'b1; wr_valid = 1'b1;
      end
    end else if (lim_bad || canon_bad) begin
      kind = FK_GP; code = sel_code;
    end else if (tgt == SR_SS && ss_bad) begin
      kind = FK_GP; code = sel_code;
    end else if (tgt != SR_SS && (dx_type_bad || dx_priv_bad)) begin
      kind = FK_GP; code = sel_code;
    end else if (!dsc.p) begin
      kind = (tgt == SR_SS) ? FK_SS : FK_NP; code = sel_code;
    end else begin
      wr_sel = 1'b1; wr_valid = 1'b1; valid_val = 1'b1; wr_attr = 1'b1;
    end
  end
endmodule

// File: rtl/seg_load_guard.sv
`timescale 1ns/1ps
module seg_load_guard import segld_pkg::*; #(
  parameter int OFF_W = 64,
  parameter int SEL_W = 16,
  localparam int IDX_W = SEL_W - 3,
  localparam int PTR_W = OFF_W + SEL_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [2:0]                mode,
  input  logic [1:0]                cpl,
  input  logic [2:0]                tgt,
  input  logic [1:0]                opsz,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [IDX_W-1:0]          tbl_limit,
  input  logic                      desc_canon,
  output logic                      desc_req,
  output logic [IDX_W-1:0]          desc_idx,
  input  logic                      desc_ack,
  input  logic [3:0]                desc_type,
  input  logic                      desc_s,
  input  logic [1:0]                desc_dpl,
  input  logic                      desc_present,
  output logic                      done,
  output logic [2:0]                fault_kind,
  output logic [15:0]               fault_code,
  output logic [OFF_W-1:0]          dest_off,
  output logic [NUM_SEG*SEL_W-1:0]  seg_sel,
  output logic [NUM_SEG-1:0]        seg_valid,
  output logic [NUM_SEG*ATTR_W-1:0] seg_attr
);
  ld_state_e        state;
  logic [2:0]       req_mode, req_tgt;
  logic [1:0]       req_cpl;
  logic [SEL_W-1:0] req_sel, split_sel;
  logic [OFF_W-1:0] req_off, split_off;
  logic [IDX_W-1:0] req_limit;
  logic             req_canon;
  desc_attr_t       dattr;

  logic        need_desc, wr_sel, wr_valid, valid_val, wr_attr, commit;
  logic [2:0]  chk_kind;
  logic [15:0] chk_code;

  segld_ptr_split #(.OFF_W(OFF_W), .SEL_W(SEL_W)) u_split (
    .ptr(ptr), .mode(mode), .opsz(opsz), .sel(split_sel), .off(split_off));

  segld_rules #(.SEL_W(SEL_W)) u_rules (
    .mode(req_mode), .cpl(req_cpl), .tgt(req_tgt), .sel(req_sel),
    .limit(req_limit), .canon(req_canon), .dsc(dattr),
    .need_desc(need_desc), .kind(chk_kind), .code(chk_code),
    .wr_sel(wr_sel), .wr_valid(wr_valid), .valid_val(valid_val), .wr_attr(wr_attr));

  assign commit   = (state == ST_CHECK);
  assign done     = (state == ST_DONE);
  assign desc_req = (state == ST_FETCH) && need_desc;
  assign desc_idx = req_sel[SEL_W-1:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      req_mode <= '0; req_tgt <= '0; req_cpl <= '0; req_sel <= '0; req_off <= '0;
      req_limit <= '0; req_canon <= 1'b0; dattr <= '0;
      fault_kind <= '0; fault_code <= '0; dest_off <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          req_mode <= mode; req_tgt <= tgt; req_cpl <= cpl;
          req_sel <= split_sel; req_off <= split_off;
          req_limit <= tbl_limit; req_canon <= desc_canon;
          state <= ST_FETCH;
        end
        ST_FETCH: if (!need_desc) begin
          state <= ST_CHECK;
        end else if (desc_ack) begin
          dattr <= '{p: desc_present, dpl: desc_dpl, s: desc_s, typ: desc_type};
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          fault_kind <= chk_kind;
          fault_code <= chk_code;
          if (wr_sel) dest_off <= req_off;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = commit && (req_tgt == 3'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_sel[g*SEL_W +: SEL_W]    <= '0;
        seg_valid[g]                 <= 1'b0;
        seg_attr[g*ATTR_W +: ATTR_W] <= '0;
      end else if (hit) begin
        if (wr_sel)   seg_sel[g*SEL_W +: SEL_W]    <= req_sel;
        if (wr_valid) seg_valid[g]                 <= valid_val;
        if (wr_attr)  seg_attr[g*ATTR_W +: ATTR_W] <= dattr;
      end
    end
  end
endmodule

// File: rtl/segld_chk.sv
`timescale 1ns/1ps
module segld_chk import segld_pkg::*; #(
  parameter int OFF_W = 64,
  parameter int SEL_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      done,
  input logic                      desc_req,
  input logic                      desc_ack,
  input logic [2:0]                fault_kind,
  input logic [15:0]               fault_code,
  input logic [OFF_W-1:0]          dest_off,
  input logic [NUM_SEG*SEL_W-1:0]  seg_sel,
  input logic [NUM_SEG-1:0]        seg_valid,
  input logic [NUM_SEG*ATTR_W-1:0] seg_attr
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
    (desc_req && !desc_ack) |=> desc_req);
  p_no_req_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !desc_req);
  p_fault_steady_r10: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(fault_kind) || done);
  p_fault_keeps_state_r9: assert property (@(posedge clk) disable iff (rst)
    (done && fault_kind != FK_NONE) |->
      (seg_sel == $past(seg_sel) && seg_valid == $past(seg_valid) &&
       seg_attr == $past(seg_attr) && dest_off == $past(dest_off)));
  p_ud_code_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done && fault_kind == FK_UD) |-> fault_code == 16'd0);
  p_code_rpl_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (done && fault_kind != FK_NONE) |-> fault_code[1:0] == 2'b00);
  p_state_moves_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(seg_sel) |-> done);
endmodule

bind seg_load_guard segld_chk #(.OFF_W(OFF_W), .SEL_W(SEL_W)) u_segld_chk (
  .clk(clk), .rst(rst), .done(done), .desc_req(desc_req), .desc_ack(desc_ack),
  .fault_kind(fault_kind), .fault_code(fault_code), .dest_off(dest_off),
  .seg_sel(seg_sel), .seg_valid(seg_valid), .seg_attr(seg_attr));

// File: tb/tb_seg_load_guard.sv
`timescale 1ns/1ps
module tb_seg_load_guard;
  import segld_pkg::*;
  localparam int OW = 64, SW = 16, IW = SW - 3, PW = OW + SW, NS = NUM_SEG, AW = ATTR_W;
  localparam int NV = 32;

  typedef struct packed {
    logic [2:0] mode; logic [1:0] cpl; logic [2:0] tgt; logic [1:0] opsz;
    logic [15:0] sel; logic [3:0] typ; logic s; logic [1:0] dpl; logic p;
    logic canon; logic [12:0] lim; logic [2:0] kind; logic fetch; logic [3:0] rq;
  } vec_t;

  // type codes: 2 writable data, 0 read-only data, 8 exec-only code, A readable code, E conforming readable code
  localparam vec_t VECS [NV] = '{
    '{3'd0,2'd0,3'd1,2'd0,16'h1234,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b0,4'd2},  // R2 real DS
    '{3'd1,2'd3,3'd0,2'd1,16'h0000,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b0,4'd2},  // R2 v86 SS null
    '{3'd2,2'd0,3'd1,2'd1,16'h0002,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b0,4'd3},  // R3
    '{3'd2,2'd0,3'd0,2'd1,16'h0000,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b0,4'd4},  // R4
    '{3'd3,2'd0,3'd0,2'd1,16'h0003,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b0,4'd4},  // R4
    '{3'd4,2'd0,3'd0,2'd1,16'h0000,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b0,4'd4},  // R4 accepted
    '{3'd4,2'd3,3'd0,2'd1,16'h0003,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b0,4'd4},  // R4 rpl 3
    '{3'd4,2'd0,3'd0,2'd1,16'h0001,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b0,4'd4},  // R4 rpl!=cpl
    '{3'd4,2'd0,3'd1,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd4,1'b0,4'd7},  // R7 DS
    '{3'd4,2'd0,3'd2,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd4,1'b0,4'd7},  // R7 ES
    '{3'd2,2'd0,3'd0,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd8},  // R8 SS ok
    '{3'd2,2'd0,3'd0,2'd1,16'h0029,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd5},  // R5 rpl
    '{3'd2,2'd0,3'd0,2'd1,16'h0028,4'h0,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd5},  // R5 read-only
    '{3'd2,2'd0,3'd0,2'd1,16'h0028,4'h2,1'b1,2'd1,1'b1,1'b1,13'd100,3'd1,1'b1,4'd5},  // R5 dpl
    '{3'd2,2'd0,3'd0,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b0,1'b1,13'd100,3'd2,1'b1,4'd5},  // R5 not present
    '{3'd2,2'd0,3'd0,2'd1,16'h0328,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b0,4'd7},  // R7 index 101
    '{3'd2,2'd0,3'd0,2'd1,16'h0028,4'hA,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd5},  // R5 code
    '{3'd2,2'd0,3'd1,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd8},  // R8 DS ok
    '{3'd2,2'd0,3'd1,2'd1,16'h002B,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd6},  // R6 rpl>dpl
    '{3'd2,2'd3,3'd1,2'd1,16'h002B,4'hE,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd6},  // R6 conforming
    '{3'd2,2'd3,3'd1,2'd1,16'h002B,4'hA,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd6},  // R6 nonconf
    '{3'd2,2'd0,3'd3,2'd1,16'h0028,4'h8,1'b1,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd6},  // R6 exec-only
    '{3'd2,2'd0,3'd4,2'd1,16'h0028,4'h2,1'b0,2'd0,1'b1,1'b1,13'd100,3'd1,1'b1,4'd6},  // R6 system
    '{3'd2,2'd0,3'd2,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b0,1'b1,13'd100,3'd3,1'b1,4'd6},  // R6 NP
    '{3'd4,2'd0,3'd3,2'd2,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd1},  // R1 wide
    '{3'd4,2'd0,3'd4,2'd1,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b0,13'd100,3'd1,1'b0,4'd7},  // R7 canon
    '{3'd4,2'd0,3'd3,2'd1,16'h0000,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b0,4'd3},  // R3 64 FS
    '{3'd3,2'd0,3'd4,2'd2,16'h0028,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd1},  // R1 wide ignored
    '{3'd2,2'd0,3'd1,2'd1,16'h0320,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd7},  // R7 index==limit
    '{3'd2,2'd0,3'd1,2'd0,16'h0030,4'h2,1'b1,2'd0,1'b1,1'b1,13'd100,3'd0,1'b1,4'd1},  // R1 16-bit
    '{3'd2,2'd0,3'd0,2'd1,16'h0029,4'h2,1'b1,2'd0,1'b0,1'b1,13'd100,3'd1,1'b1,4'd5},  // R5 GP before SS
    '{3'd2,2'd3,3'd1,2'd1,16'h002B,4'h2,1'b1,2'd3,1'b0,1'b1,13'd100,3'd3,1'b1,4'd6}   // R6 NP only
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst = 1'b1, start = 1'b0;
  logic [2:0] mode = '0, tgt = '0;
  logic [1:0] cpl = '0, opsz = '0;
  logic [PW-1:0] ptr = '0;
  logic [IW-1:0] tbl_limit = '0;
  logic desc_canon = 1'b1, desc_req, desc_ack, done;
  logic [IW-1:0] desc_idx;
  logic [2:0] fault_kind;
  logic [15:0] fault_code;
  logic [OW-1:0] dest_off;
  logic [NS*SW-1:0] seg_sel;
  logic [NS-1:0] seg_valid;
  logic [NS*AW-1:0] seg_attr;
  vec_t cur = '0;
  int n_chk = 0, n_fail = 0, ack_delay = 0, ack_cnt = 0, req_cycles = 0;

  seg_load_guard #(.OFF_W(OW), .SEL_W(SW)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .cpl(cpl), .tgt(tgt),
    .opsz(opsz), .ptr(ptr), .tbl_limit(tbl_limit), .desc_canon(desc_canon),
    .desc_req(desc_req), .desc_idx(desc_idx), .desc_ack(desc_ack),
    .desc_type(cur.typ), .desc_s(cur.s), .desc_dpl(cur.dpl), .desc_present(cur.p),
    .done(done), .fault_kind(fault_kind), .fault_code(fault_code),
    .dest_off(dest_off), .seg_sel(seg_sel), .seg_valid(seg_valid), .seg_attr(seg_attr));

  always @(posedge clk) begin
    if (rst) begin
      desc_ack <= 1'b0; ack_cnt <= 0;
    end else begin
      if (desc_req) req_cycles <= req_cycles + 1;
      if (desc_req && !desc_ack) begin
        if (ack_cnt >= ack_delay) begin desc_ack <= 1'b1; ack_cnt <= 0; end
        else ack_cnt <= ack_cnt + 1;
      end else desc_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_code(input vec_t v);
    if ((v.kind == 3'd1 || v.kind == 3'd2 || v.kind == 3'd3) && v.sel[15:2] != 14'd0)
      return {v.sel[15:2], 2'b00};
    return 16'd0;
  endfunction

  task automatic run_vec(input vec_t v, input int i);
    logic [NS*SW-1:0] s_sel; logic [NS-1:0] s_val; logic [NS*AW-1:0] s_attr;
    logic [OW-1:0] s_off, off, e_off;
    bit fetched; int wn; string tg; bit prot_m, nul;
    tg = $sformatf("R%0d", v.rq);
    @(negedge clk);
    s_sel = seg_sel; s_val = seg_valid; s_attr = seg_attr; s_off = dest_off;
    cur = v;
    off = {32'hC0DE0000 + 32'(i), 32'hFACE1000 + 32'(i)};
    if (v.opsz == 2'd2 && v.mode == 3'd4) begin ptr = {v.sel, off}; e_off = off; end
    else if (v.opsz == 2'd0) begin ptr = {32'hDEADBEEF, 16'hA5A5, v.sel, off[15:0]}; e_off = {48'd0, off[15:0]}; end
    else begin ptr = {32'hBAD0F00D, v.sel, off[31:0]}; e_off = {32'd0, off[31:0]}; end
    mode = v.mode; cpl = v.cpl; tgt = v.tgt; opsz = v.opsz;
    tbl_limit = v.lim; desc_canon = v.canon; start = 1'b1;
    @(negedge clk);
    start = 1'b0; fetched = 0; wn = 0;
    while (!done && wn < 200) begin
      if (desc_req) fetched = 1;
      @(negedge clk); wn++;
    end
    chk(done, "R10 completion", 64'(done), 64'd1);
    chk(fault_kind == v.kind, tg, 64'(fault_kind), 64'(v.kind));
    chk(fault_code == exp_code(v), tg, 64'(fault_code), 64'(exp_code(v)));
    chk(fetched == v.fetch, tg, 64'(fetched), 64'(v.fetch));
    if (v.kind != 3'd0) begin
      chk(seg_sel == s_sel && seg_valid == s_val && seg_attr == s_attr && dest_off == s_off,
          "R9", dest_off, s_off);
    end else begin
      prot_m = (v.mode >= 3'd2 && v.mode <= 3'd4);
      nul = (v.sel[15:2] == 14'd0);
      chk(dest_off == e_off, "R1", dest_off, e_off);
      for (int k = 0; k < NS; k++) begin
        if (k == int'(v.tgt)) chk(seg_sel[k*SW +: SW] == v.sel, tg, 64'(seg_sel[k*SW +: SW]), 64'(v.sel));
        else chk(seg_sel[k*SW +: SW] == s_sel[k*SW +: SW], tg, 64'(seg_sel[k*SW +: SW]), 64'(s_sel[k*SW +: SW]));
      end
      if (!prot_m)
        chk(seg_valid == s_val && seg_attr == s_attr, "R2", 64'(seg_valid), 64'(s_val));
      else if (nul)
        chk(seg_valid[v.tgt] == 1'b0 && seg_attr == s_attr, "R3", 64'(seg_valid), 64'(s_val));
      else begin
        chk(seg_valid[v.tgt] == 1'b1, "R8", 64'(seg_valid[v.tgt]), 64'd1);
        chk(seg_attr[int'(v.tgt)*AW +: AW] == {v.p, v.dpl, v.s, v.typ}, "R8",
            64'(seg_attr[int'(v.tgt)*AW +: AW]), 64'({v.p, v.dpl, v.s, v.typ}));
      end
    end
    @(negedge clk);
    chk(!done, "R10 pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(seg_sel == '0 && seg_valid == '0 && seg_attr == '0, "R11", 64'(seg_valid), 64'd0);
    chk(dest_off == '0 && fault_kind == 3'd0 && fault_code == 16'd0, "R11", dest_off, 64'd0);
    chk(!done && !desc_req, "R11", 64'({done, desc_req}), 64'd0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // R10: fault outputs hold while idle
    run_vec(VECS[3], 40);
    repeat (3) @(negedge clk);
    chk(fault_kind == 3'd1, "R10 hold", 64'(fault_kind), 64'd1);
    // R10: request held through a slow acknowledge
    ack_delay = 4; req_cycles = 0;
    run_vec(VECS[17], 41);
    chk(req_cycles >= 5, "R10 slow ack", 64'(req_cycles), 64'd5);
    ack_delay = 0;
    run_vec(VECS[24], 42);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule